// File: doc/BRIEF.md
# Two-Channel Block Burst DMA Sequencer

This block moves data between system memory and a pair of FIFOs in fixed bursts of sixteen words. The transmit channel reads words from memory and pushes them into the transmit FIFO. The receive channel pops words from the receive FIFO and writes them to memory. A channel never waits for a per-burst start command. It starts a burst on its own when its FIFO reports a level condition: programmable-empty for transmit, programmable-full for receive. A started burst always runs to its end.

Software programs each channel with three things: a start address, a 32-bit count word whose upper 24 bits give the number of bursts, and an enable. On the rising edge of the enable, the channel copies the address and the count into private working registers. Later changes to the programmed values do not reach a running channel. Both channels share one word-wide memory master, which uses request and acknowledge. When both channels want the bus at the same moment, they take turns, one burst each.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset, `mem_req_o`, `txf_wr_o`, `rxf_rd_o`, `tx_done_o` and `rx_done_o` are all 0.
- R2: A 0-to-1 transition on a channel enable copies that channel's base address and count. Changing `*_base_i` or `*_num_i` while the channel runs does not change the addresses it issues or the number of bursts it moves.
- R3: The first word of a run uses the latched base address. Each acknowledged word advances that channel's address by 4. The address carries on across bursts of the same channel.
- R4: A burst is exactly 16 acknowledged words. Within a burst, `mem_req_o` stays high with a stable address until each acknowledge. After the 16th acknowledge, `mem_req_o` is low for at least one cycle.
- R5: Transmit words are memory reads (`mem_we_o`=0). On each acknowledge, `txf_wr_o` pulses in the same cycle with `txf_wdata_o` equal to `mem_rdata_i`.
- R6: Receive words are memory writes (`mem_we_o`=1) with `mem_wdata_o` equal to `rxf_rdata_i`, the FIFO head. On each acknowledge, `rxf_rd_o` pulses in the same cycle to pop it.
- R7: The burst count is bits 31:8 of `*_num_i`. Bits 7:0 have no effect.
- R8: `*_done_o` is 0 while bursts remain and 1 once all programmed bursts are moved. A count of 0 gives done in the cycle after the enable edge. After done, the channel issues no further words.
- R9: When both channels request at the same time, bursts alternate between transmit and receive.
- R10: Deasserting a channel's enable or its trigger in the middle of a burst does not shorten that burst. No new burst starts afterwards, and done stays 0 if bursts remain.
- R11: A new enable edge with a nonzero count clears `*_done_o` in the following cycle.
- R12: An enabled channel whose trigger is low issues no memory request.
- R13: Address bits 1:0 of the programmed base are ignored. Every issued address is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit channel enable; the rising edge latches the setup |
| tx_base_i | input | AW | Transmit start address |
| tx_num_i | input | NUM_W | Transmit count word; the burst count is in bits 31:8 |
| tx_done_o | output | 1 | All transmit bursts moved |
| rx_en_i | input | 1 | Receive channel enable; the rising edge latches the setup |
| rx_base_i | input | AW | Receive start address |
| rx_num_i | input | NUM_W | Receive count word; the burst count is in bits 31:8 |
| rx_done_o | output | 1 | All receive bursts moved |
| tx_prog_empty_i | input | 1 | Transmit FIFO programmable-empty; triggers transmit bursts |
| rx_prog_full_i | input | 1 | Receive FIFO programmable-full; triggers receive bursts |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write (receive), 0 = read (transmit) |
| mem_addr_o | output | AW | Byte address of the current word |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Word acknowledge |
| txf_wr_o | output | 1 | Push strobe to the transmit FIFO |
| txf_wdata_o | output | DW | Data pushed to the transmit FIFO |
| rxf_rd_o | output | 1 | Pop strobe to the receive FIFO |
| rxf_rdata_i | input | DW | Receive FIFO head word |

## Verification
Two functions can fall in the same cycle: a transmit trigger and a receive trigger, competing for the single memory master. The bench provokes this by enabling both channels with their triggers low, then raising both triggers on the same clock. The logged words are then split into bursts. The bench judges arbitration from the direction bit of each burst: neighbouring bursts must differ, each burst must keep one direction, and each channel's addresses must carry on from its previous burst. A second collision, between a running burst and an enable or trigger falling in the middle of it, is checked by counting words after the burst ends.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  localparam int NCH   = 2;
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BURST = 1'b1
  } seq_e;
endpackage

// File: rtl/blk_dma_chan.sv
module blk_dma_chan #(
  parameter int AW        = 32,
  parameter int NUM_W     = 32,
  parameter int CNT_LSB   = 8,
  parameter int ADDR_STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic          trig_i,
  input  logic          word_i,
  input  logic          blk_end_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam int CNT_W = NUM_W - CNT_LSB;
  localparam int AL    = $clog2(ADDR_STEP);

  logic             en_q;
  logic             loaded_q;
  logic [CNT_W-1:0] rem_q;
  logic [AW-1:0]    addr_q;
  logic             en_rise;

  assign en_rise = en_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      loaded_q <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
    end else begin
      en_q <= en_i;
      if (en_rise) begin
        addr_q   <= {base_i[AW-1:AL], {AL{1'b0}}};
        rem_q    <= num_i[NUM_W-1:CNT_LSB];
        loaded_q <= 1'b1;
      end else begin
        if (word_i)    addr_q <= addr_q + AW'(ADDR_STEP);
        if (blk_end_i) rem_q  <= rem_q - 1'b1;
      end
    end
  end

  // a burst is only asked for with a live setup, blocks left and the FIFO flag up
  assign req_o  = en_q & loaded_q & (rem_q != '0) & trig_i;
  assign addr_o = addr_q;
  assign done_o = loaded_q & (rem_q == '0);

  AST_DONE_CLR_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise && (num_i[NUM_W-1:CNT_LSB] != '0) |=> !done_o); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_i |-> (rem_q != '0)); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_i && !en_rise |=> $stable(addr_q)); // R2
endmodule

// File: rtl/blk_dma_arb.sv
module blk_dma_arb #(
  parameter int N = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  input  logic                 take_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  // round robin: search starts one past the last winner
  always_comb begin
    int  c;
    logic found;
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      c = int'(last_q) + off;
      if (c >= N) c = c - N;
      if (!found && req_i[c]) begin
        found    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                last_q <= IW'(N - 1);
    else if (take_i && |req_i)  last_q <= idx_o;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R9
  AST_GNT_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R12
  AST_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (&req_i) |=> (last_q != $past(last_q))); // R9
endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import blk_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NUM_W     = 32,
  parameter int CNT_LSB   = 8,
  parameter int BLK_WORDS = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic [AW-1:0]    tx_base_i,
  input  logic [NUM_W-1:0] tx_num_i,
  output logic             tx_done_o,
  input  logic             rx_en_i,
  input  logic [AW-1:0]    rx_base_i,
  input  logic [NUM_W-1:0] rx_num_i,
  output logic             rx_done_o,
  input  logic             tx_prog_empty_i,
  input  logic             rx_prog_full_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i,
  output logic             txf_wr_o,
  output logic [DW-1:0]    txf_wdata_o,
  output logic             rxf_rd_o,
  input  logic [DW-1:0]    rxf_rdata_i
);
  localparam int WC_W = $clog2(BLK_WORDS);
  localparam int IW   = $clog2(NCH);
  localparam int AL   = $clog2(ADDR_STEP);

  logic [NCH-1:0]   ch_en, ch_trig, ch_req, ch_done, ch_word, ch_end, gnt;
  logic [AW-1:0]    ch_base [NCH];
  logic [NUM_W-1:0] ch_num  [NCH];
  logic [AW-1:0]    ch_addr [NCH];
  logic [IW-1:0]    gnt_idx;

  seq_e            st_q;
  logic [IW-1:0]   sel_q;
  logic [WC_W-1:0] wcnt_q;
  logic            blk_last;
  logic            take;

  assign ch_en[CH_TX]   = tx_en_i;
  assign ch_en[CH_RX]   = rx_en_i;
  assign ch_trig[CH_TX] = tx_prog_empty_i;
  assign ch_trig[CH_RX] = rx_prog_full_i;
  assign ch_base[CH_TX] = tx_base_i;
  assign ch_base[CH_RX] = rx_base_i;
  assign ch_num[CH_TX]  = tx_num_i;
  assign ch_num[CH_RX]  = rx_num_i;
  assign tx_done_o      = ch_done[CH_TX];
  assign rx_done_o      = ch_done[CH_RX];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_word[c] = (st_q == SEQ_BURST) && mem_ack_i && (sel_q == IW'(c));
    assign ch_end[c]  = ch_word[c] & blk_last;

    blk_dma_chan #(
      .AW(AW), .NUM_W(NUM_W), .CNT_LSB(CNT_LSB), .ADDR_STEP(ADDR_STEP)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ch_en[c]),
      .base_i   (ch_base[c]),
      .num_i    (ch_num[c]),
      .trig_i   (ch_trig[c]),
      .word_i   (ch_word[c]),
      .blk_end_i(ch_end[c]),
      .req_o    (ch_req[c]),
      .addr_o   (ch_addr[c]),
      .done_o   (ch_done[c])
    );
  end

  assign take = (st_q == SEQ_IDLE);

  blk_dma_arb #(.N(NCH)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (ch_req),
    .take_i(take),
    .gnt_o (gnt),
    .idx_o (gnt_idx)
  );

  assign blk_last = (wcnt_q == WC_W'(BLK_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      sel_q  <= '0;
      wcnt_q <= '0;
    end else if (st_q == SEQ_IDLE) begin
      if (|gnt) begin
        st_q   <= SEQ_BURST;
        sel_q  <= gnt_idx;
        wcnt_q <= '0;
      end
    end else if (mem_ack_i) begin
      wcnt_q <= wcnt_q + 1'b1;
      if (blk_last) st_q <= SEQ_IDLE;
    end
  end

  assign mem_req_o   = (st_q == SEQ_BURST);
  assign mem_we_o    = mem_req_o && (sel_q == IW'(CH_RX));
  assign mem_addr_o  = ch_addr[sel_q];
  assign mem_wdata_o = rxf_rdata_i;
  assign txf_wr_o    = ch_word[CH_TX];
  assign txf_wdata_o = mem_rdata_i;
  assign rxf_rd_o    = ch_word[CH_RX];

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !blk_last |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + AW'(ADDR_STEP))); // R3
  AST_BLK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && blk_last |=> !mem_req_o); // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[AL-1:0] == '0)); // R13
  AST_TX_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_wr_o |-> mem_ack_i && !mem_we_o); // R5
  AST_RX_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_rd_o |-> mem_ack_i && mem_we_o); // R6
  AST_FIFO_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txf_wr_o && rxf_rd_o)); // R5
endmodule

// File: tb/blk_dma_engine_test.sv
module blk_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_en_i = 1'b0, rx_en_i = 1'b0;
  logic [31:0] tx_base_i = '0, rx_base_i = '0, tx_num_i = '0, rx_num_i = '0;
  logic        tx_prog_empty_i = 1'b0, rx_prog_full_i = 1'b0;
  logic        tx_done_o, rx_done_o;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic        txf_wr_o, rxf_rd_o;
  logic [31:0] txf_wdata_o, rxf_rdata_i;

  int n_cmp = 0, n_mis = 0, cyc = 0, rx_head = 0, n_log = 0;
  bit finished = 1'b0;
  logic [31:0] l_addr [512];
  logic [31:0] l_wdata[512];
  logic        l_we   [512];
  logic        l_ok   [512];
  int          l_cyc  [512];

  always #4 clk = ~clk;

  blk_dma_engine uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_en_i(tx_en_i), .tx_base_i(tx_base_i), .tx_num_i(tx_num_i), .tx_done_o(tx_done_o),
    .rx_en_i(rx_en_i), .rx_base_i(rx_base_i), .rx_num_i(rx_num_i), .rx_done_o(rx_done_o),
    .tx_prog_empty_i(tx_prog_empty_i), .rx_prog_full_i(rx_prog_full_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .txf_wr_o(txf_wr_o), .txf_wdata_o(txf_wdata_o),
    .rxf_rd_o(rxf_rd_o), .rxf_rdata_i(rxf_rdata_i)
  );

  assign rxf_rdata_i = 32'hC300_0000 | rx_head;

  always @(posedge clk) if (rxf_rd_o) rx_head <= rx_head + 1;

  // zero-wait memory: acknowledge every request, log each word
  always @(negedge clk) begin
    cyc++;
    mem_ack_i   = mem_req_o;
    mem_rdata_i = mem_addr_o ^ 32'h5A5A_0000;
    #1;
    if (mem_ack_i && n_log < 512) begin
      l_addr[n_log]  = mem_addr_o;
      l_we[n_log]    = mem_we_o;
      l_wdata[n_log] = mem_wdata_o;
      l_cyc[n_log]   = cyc;
      l_ok[n_log]    = mem_we_o ? (rxf_rd_o && !txf_wr_o && mem_wdata_o == rxf_rdata_i)
                                : (txf_wr_o && !rxf_rd_o && txf_wdata_o == mem_rdata_i);
      n_log++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_done(input bit rx, input string tag);
    int t = 0;
    while (((rx ? rx_done_o : tx_done_o) !== 1'b1) && t < 400) begin
      step(1);
      t++;
    end
    chk(tag, 32'(rx ? rx_done_o : tx_done_o), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", 32'(mem_req_o), 0);
    chk("R1 fifo strobes", {30'd0, txf_wr_o, rxf_rd_o}, 0);
    chk("R1 done", {30'd0, tx_done_o, rx_done_o}, 0);
  endtask

  task automatic t_tx_basic();
    int s = n_log;
    bit bad_a = 0, bad_ok = 0, bad_run = 0;
    tx_base_i = 32'h1000_0003; tx_num_i = 32'h0000_02FF; tx_prog_empty_i = 1'b1;
    tx_en_i = 1'b1;
    step(1);
    tx_base_i = 32'hDEAD_0000; tx_num_i = 32'h0000_0700;  // R2 later writes
    step(10);
    chk("R8 done low while blocks remain", 32'(tx_done_o), 0);
    wait_done(1'b0, "R8 tx done after two blocks");
    chk("R7 R2 word count", 32'(n_log - s), 32);
    for (int k = 0; k < 32; k++) begin
      if (l_addr[s+k] !== 32'h1000_0000 + 32'(4*k) || l_we[s+k] !== 1'b0) bad_a = 1;
      if (l_ok[s+k] !== 1'b1) bad_ok = 1;
      if (k != 15 && k < 31 && l_cyc[s+k+1] - l_cyc[s+k] != 1) bad_run = 1;
    end
    chk("R3 R13 tx addresses", 32'(bad_a), 0);
    chk("R5 tx fifo push data", 32'(bad_ok), 0);
    chk("R4 back-to-back within burst", 32'(bad_run), 0);
    chk("R4 idle gap between bursts", 32'(l_cyc[s+16] - l_cyc[s+15] >= 2), 1);
    step(30);
    chk("R8 no words after done", 32'(n_log - s), 32);
    tx_en_i = 1'b0;
    step(2);
  endtask

  task automatic t_reenable();
    int s;
    tx_prog_empty_i = 1'b0; tx_num_i = 32'h0000_0100; tx_base_i = 32'h1100_0000;
    tx_en_i = 1'b1;
    step(1);
    chk("R11 done cleared by new enable", 32'(tx_done_o), 0);
    s = n_log;
    step(20);
    chk("R12 no request without trigger", 32'(n_log - s), 0);
    chk("R12 mem_req low", 32'(mem_req_o), 0);
    tx_prog_empty_i = 1'b1;
    wait_done(1'b0, "R8 done after one block");
    chk("R8 one block moved", 32'(n_log - s), 16);
    tx_en_i = 1'b0; tx_prog_empty_i = 1'b0;
    step(2);
    tx_num_i = 32'h0000_00FF;
    tx_en_i = 1'b1;
    step(1);
    chk("R8 R7 zero count done at once", 32'(tx_done_o), 1);
    tx_en_i = 1'b0;
    step(2);
  endtask

  task automatic t_rx_basic();
    int s = n_log;
    int h0 = rx_head;
    bit bad = 0;
    rx_base_i = 32'h2000_0041; rx_num_i = 32'h0000_0100; rx_prog_full_i = 1'b1;
    rx_en_i = 1'b1;
    wait_done(1'b1, "R8 rx done");
    chk("R6 rx word count", 32'(n_log - s), 16);
    for (int k = 0; k < 16; k++)
      if (l_we[s+k] !== 1'b1 || l_addr[s+k] !== 32'h2000_0040 + 32'(4*k) ||
          l_wdata[s+k] !== (32'hC300_0000 | 32'(h0 + k)) || l_ok[s+k] !== 1'b1) bad = 1;
    chk("R6 R13 rx writes from fifo head", 32'(bad), 0);
    rx_en_i = 1'b0; rx_prog_full_i = 1'b0;
    step(2);
  endtask

  task automatic t_arb();
    int s = n_log;
    bit bad_alt = 0, bad_mix = 0;
    tx_base_i = 32'h3000_0000; tx_num_i = 32'h0000_0200;
    rx_base_i = 32'h4000_0000; rx_num_i = 32'h0000_0200;
    tx_en_i = 1'b1; rx_en_i = 1'b1;
    step(2);
    tx_prog_empty_i = 1'b1; rx_prog_full_i = 1'b1;  // same-cycle collision
    wait_done(1'b0, "R9 tx done under contention");
    wait_done(1'b1, "R9 rx done under contention");
    chk("R9 total words", 32'(n_log - s), 64);
    for (int b = 0; b < 4; b++) begin
      for (int k = 1; k < 16; k++) if (l_we[s+16*b+k] !== l_we[s+16*b]) bad_mix = 1;
      if (b < 3 && l_we[s+16*b] === l_we[s+16*(b+1)]) bad_alt = 1;
    end
    chk("R10 burst keeps one direction", 32'(bad_mix), 0);
    chk("R9 bursts alternate", 32'(bad_alt), 0);
    chk("R3 address carries across bursts", l_addr[s+32] & 32'h0000_FFFF, 32'h0000_0040);
    tx_en_i = 1'b0; rx_en_i = 1'b0; tx_prog_empty_i = 1'b0; rx_prog_full_i = 1'b0;
    step(2);
  endtask

  task automatic t_stop();
    int s = n_log;
    int t = 0;
    tx_base_i = 32'h5000_0000; tx_num_i = 32'h0000_0500; tx_prog_empty_i = 1'b1;
    tx_en_i = 1'b1;
    while (n_log - s < 5 && t < 100) begin step(1); t++; end
    tx_en_i = 1'b0; tx_prog_empty_i = 1'b0;
    step(60);
    chk("R10 burst finished after stop", 32'(n_log - s), 16);
    chk("R10 done low with blocks left", 32'(tx_done_o), 0);
    chk("R10 bus idle after stop", 32'(mem_req_o), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  endtask

  initial begin
    step(3);
    t_reset();
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_tx_basic();
    t_reenable();
    t_rx_basic();
    t_arb();
    t_stop();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_mis++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule